// File: doc/BRIEF.md
# Press-Duration Reset and Interrupt Controller

This block turns a debounced, active-low push-button level into a system reset request and a pair of press-event interrupt flags. One of three behaviours is chosen at run time. In level mode the reset request follows the pressed button and drops only once the button is released. In pulse mode a press yields a single one-cycle reset request, so the system reboots at once and software can time the rest of the press itself. In interrupt mode the block measures how long the button stays down and raises a short-press flag, then a long-press flag. If the long-press flag is left uncleared for an acknowledge window while the button is still held, it falls back to a reset that lasts until release.

All durations are counted in ticks of a one-millisecond enable pulse supplied by the surrounding logic. Three small select codes pick the short-press threshold, the extra long-press time and the acknowledge window. While the system sleeps, either press event also raises a one-cycle wake request with a reason code. The flags are sticky and are cleared by write-one-to-clear strobes. All pins are plain control and status signals: no data stream passes through the block, so there is no valid/ready handshake.

Top module: `press_rst_ctrl`

## Requirements
- R1: With mode code 00 (level), `sys_rst_req` is high on the clock after `pin_lvl` is sampled low, and low on the clock after `pin_lvl` is sampled high.
- R2: With mode codes 10 or 11 (pulse), each high-to-low change of `pin_lvl` gives exactly one cycle of `sys_rst_req`, one clock after the low level is sampled. Holding the pin low gives no further reset.
- R3: With mode code 01 (interrupt), a press whose low tick count never reaches Tsp sets no flag, raises no wake request and causes no reset.
- R4: The press counter adds one on each clock where `ms_tick` is high and `pin_lvl` is low. `sp_flag` rises one clock after the count first equals or exceeds Tsp. With `ms_tick` high on every cycle this is the (Tsp+1)-th clock after the pin goes low, and the 1st clock when Tsp is 0.
- R5: `lp_flag` rises one clock after the count reaches Tsp+Tlp, and only after `sp_flag` has been set during the same press. The two flags never rise in the same cycle.
- R6: If no `lp_clr` strobe arrives while the long-press flag is pending and the count reaches Tsp+Tlp+Tack with the pin still low, `sys_rst_req` rises on the next clock. It then stays high until the clock after `pin_lvl` is sampled high.
- R7: After an `lp_clr` strobe during a pending long press, no flag is set and no reset is raised for the rest of that press, however long it lasts.
- R8: In interrupt mode, a press released before the count reaches Tsp+Tlp+Tack never raises `sys_rst_req`.
- R9: When a short- or long-press event occurs with `sleep_i` high, `wake_req` is high for one cycle together with the flag. `wake_reason` is 01 for a short press and 10 for a long press, and 00 when there is no wake request. No wake request is raised with `sleep_i` low.
- R10: Tsp is 50 ms times `sp_sel` (0 to 350 ms). Tlp is 1000 ms plus 500 ms times `lp_sel` (1000 to 4500 ms). Tack is 50, 100, 200 or 400 ms for `ack_sel` 0 to 3.
- R11: Each flag stays high until a clear strobe for that flag is sampled. A set event and a clear strobe in the same cycle leave the flag set. `irq` is the OR of the two flags. Both flags are low after reset.
- R12: The press counter returns to zero whenever `pin_lvl` is high, so every press is timed from its own start. Clock cycles without `ms_tick` do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 1 | Debounced button level, low means pressed |
| mode_sel | input | 2 | 00 level, 01 interrupt, 1x pulse |
| sp_sel | input | 3 | Short-press threshold select |
| lp_sel | input | 3 | Long-press extra time select |
| ack_sel | input | 2 | Acknowledge window select |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sleep_i | input | 1 | System is asleep |
| sp_clr | input | 1 | Clear strobe for the short-press flag |
| lp_clr | input | 1 | Clear strobe for the long-press flag (acknowledge) |
| sys_rst_req | output | 1 | System reset request |
| sp_flag | output | 1 | Short-press interrupt flag |
| lp_flag | output | 1 | Long-press interrupt flag |
| irq | output | 1 | Either flag set |
| wake_req | output | 1 | One-cycle wake request |
| wake_reason | output | 2 | 01 short press, 10 long press |

## Verification
The bench probes the exact tick on which each threshold is crossed for several select codes, including Tsp of zero and the largest codes. A comparator off by one there would move the flag by a cycle or merge the short and long events. A press that ends one tick before the reset deadline checks that the design does not reset early. An acknowledge followed by a very long hold checks that a design which forgets the acknowledge, or restarts the sequence, would raise late flags or a reset. Sparse ticks and back-to-back presses expose a counter that counts clocks or keeps its value across presses. Holding a clear strobe across the set cycle catches a design in which clear wins.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam int SP_SEL_W  = 3;
  localparam int LP_SEL_W  = 3;
  localparam int ACK_SEL_W = 2;

  localparam logic [1:0] MODE_LEVEL = 2'b00;
  localparam logic [1:0] MODE_IRQ   = 2'b01;

  localparam logic [1:0] WAKE_NONE  = 2'b00;
  localparam logic [1:0] WAKE_SHORT = 2'b01;
  localparam logic [1:0] WAKE_LONG  = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHORT,
    PH_LONG,
    PH_ACKED,
    PH_HOLD
  } phase_e;

endpackage

// File: rtl/prc_thresholds.sv
module prc_thresholds
  import prc_pkg::*;
#(
  parameter int TSP_STEP  = 50,
  parameter int TLP_BASE  = 1000,
  parameter int TLP_STEP  = 500,
  parameter int TACK_BASE = 50,
  parameter int CNT_W     = 13
) (
  input  logic [SP_SEL_W-1:0]  sp_sel,
  input  logic [LP_SEL_W-1:0]  lp_sel,
  input  logic [ACK_SEL_W-1:0] ack_sel,
  output logic [CNT_W-1:0]     sp_ms,
  output logic [CNT_W-1:0]     lp_ms,
  output logic [CNT_W-1:0]     rst_ms
);

  int sp_i;
  int lp_i;
  int ack_i;

  always_comb begin
    sp_i   = TSP_STEP * int'(sp_sel);
    lp_i   = sp_i + TLP_BASE + TLP_STEP * int'(lp_sel);
    ack_i  = TACK_BASE << ack_sel;
    sp_ms  = CNT_W'(sp_i);
    lp_ms  = CNT_W'(lp_i);
    rst_ms = CNT_W'(lp_i + ack_i);
  end

endmodule

// File: rtl/prc_press_timer.sv
module prc_press_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             ms_tick,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (pin_lvl) begin
      cnt_q <= '0;
    end else if (ms_tick && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/prc_phase_fsm.sv
module prc_phase_fsm
  import prc_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_mode,
  input  logic             pin_lvl,
  input  logic             lp_ack,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] sp_ms,
  input  logic [CNT_W-1:0] lp_ms,
  input  logic [CNT_W-1:0] rst_ms,
  output logic             sp_evt,
  output logic             lp_evt,
  output logic             hold_rst
);

  phase_e ph_q;
  phase_e ph_d;
  logic   low;
  logic   due;

  always_comb begin
    low    = irq_mode && !pin_lvl;
    sp_evt = 1'b0;
    lp_evt = 1'b0;
    due    = 1'b0;
    ph_d   = ph_q;
    if (!low) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (cnt >= sp_ms) begin
            sp_evt = 1'b1;
            ph_d   = PH_SHORT;
          end
        end
        PH_SHORT: begin
          if (cnt >= lp_ms) begin
            lp_evt = 1'b1;
            ph_d   = PH_LONG;
          end
        end
        PH_LONG: begin
          if (lp_ack) begin
            ph_d = PH_ACKED;
          end else if (cnt >= rst_ms) begin
            due  = 1'b1;
            ph_d = PH_HOLD;
          end
        end
        default: ph_d = ph_q;
      endcase
    end
    hold_rst = low && ((ph_q == PH_HOLD) || due);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/prc_flag.sv
module prc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/press_rst_ctrl.sv
module press_rst_ctrl
  import prc_pkg::*;
#(
  parameter int TSP_STEP_MS  = 50,
  parameter int TLP_BASE_MS  = 1000,
  parameter int TLP_STEP_MS  = 500,
  parameter int TACK_BASE_MS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_lvl,
  input  logic [1:0] mode_sel,
  input  logic [2:0] sp_sel,
  input  logic [2:0] lp_sel,
  input  logic [1:0] ack_sel,
  input  logic       ms_tick,
  input  logic       sleep_i,
  input  logic       sp_clr,
  input  logic       lp_clr,
  output logic       sys_rst_req,
  output logic       sp_flag,
  output logic       lp_flag,
  output logic       irq,
  output logic       wake_req,
  output logic [1:0] wake_reason
);

  localparam int MAX_SEL_SP  = (1 << SP_SEL_W) - 1;
  localparam int MAX_SEL_LP  = (1 << LP_SEL_W) - 1;
  localparam int MAX_ACK_MUL = 1 << ((1 << ACK_SEL_W) - 1);
  localparam int MAX_MS      = MAX_SEL_SP * TSP_STEP_MS + TLP_BASE_MS
                             + MAX_SEL_LP * TLP_STEP_MS + MAX_ACK_MUL * TACK_BASE_MS;
  localparam int CNT_W       = $clog2(MAX_MS + 2);
  localparam int N_FLAGS     = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sp_ms;
  logic [CNT_W-1:0] lp_ms;
  logic [CNT_W-1:0] rst_ms;
  logic             irq_mode;
  logic             sp_evt;
  logic             lp_evt;
  logic             hold_rst;
  logic             pin_prev;
  logic             level_req;
  logic             pulse_req;
  logic [N_FLAGS-1:0] set_v;
  logic [N_FLAGS-1:0] clr_v;
  logic [N_FLAGS-1:0] flag_v;

  assign irq_mode = (mode_sel == MODE_IRQ);

  prc_thresholds #(
    .TSP_STEP (TSP_STEP_MS),
    .TLP_BASE (TLP_BASE_MS),
    .TLP_STEP (TLP_STEP_MS),
    .TACK_BASE(TACK_BASE_MS),
    .CNT_W    (CNT_W)
  ) u_thr (
    .sp_sel (sp_sel),
    .lp_sel (lp_sel),
    .ack_sel(ack_sel),
    .sp_ms  (sp_ms),
    .lp_ms  (lp_ms),
    .rst_ms (rst_ms)
  );

  prc_press_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_lvl(pin_lvl),
    .ms_tick(ms_tick),
    .cnt    (cnt)
  );

  prc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_mode(irq_mode),
    .pin_lvl (pin_lvl),
    .lp_ack  (lp_clr),
    .cnt     (cnt),
    .sp_ms   (sp_ms),
    .lp_ms   (lp_ms),
    .rst_ms  (rst_ms),
    .sp_evt  (sp_evt),
    .lp_evt  (lp_evt),
    .hold_rst(hold_rst)
  );

  assign set_v = {lp_evt, sp_evt};
  assign clr_v = {lp_clr, sp_clr};

  for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
    prc_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_v[gi]),
      .clr  (clr_v[gi]),
      .q    (flag_v[gi])
    );
  end

  assign sp_flag = flag_v[0];
  assign lp_flag = flag_v[1];
  assign irq     = |flag_v;

  assign level_req = (mode_sel == MODE_LEVEL) && !pin_lvl;
  assign pulse_req = mode_sel[1] && pin_prev && !pin_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev    <= 1'b1;
      sys_rst_req <= 1'b0;
      wake_req    <= 1'b0;
      wake_reason <= WAKE_NONE;
    end else begin
      pin_prev    <= pin_lvl;
      sys_rst_req <= level_req || pulse_req || hold_rst;
      wake_req    <= sleep_i && (sp_evt || lp_evt);
      if (sleep_i && lp_evt)      wake_reason <= WAKE_LONG;
      else if (sleep_i && sp_evt) wake_reason <= WAKE_SHORT;
      else                        wake_reason <= WAKE_NONE;
    end
  end

endmodule

// File: rtl/prc_checker.sv
module prc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_lvl,
  input logic [1:0] mode_sel,
  input logic       sleep_i,
  input logic       sp_clr,
  input logic       lp_clr,
  input logic       sys_rst_req,
  input logic       sp_flag,
  input logic       lp_flag,
  input logic       wake_req,
  input logic [1:0] wake_reason
);

  assert_level_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !pin_lvl) |=> sys_rst_req);

  assert_level_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && pin_lvl) |=> !sys_rst_req);

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] && sys_rst_req) |=> !sys_rst_req);

  assert_pulse_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] && pin_lvl) |=> !sys_rst_req);

  assert_flags_not_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_flag) |-> !$rose(sp_flag));

  assert_irq_rst_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && pin_lvl) |=> !sys_rst_req);

  assert_wake_reason_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_reason == 2'b01 || wake_reason == 2'b10));

  assert_no_wake_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_req);

  assert_sp_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_flag && !sp_clr) |=> sp_flag);

  assert_lp_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_flag && !lp_clr) |=> lp_flag);

endmodule

bind press_rst_ctrl prc_checker u_prc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_lvl    (pin_lvl),
  .mode_sel   (mode_sel),
  .sleep_i    (sleep_i),
  .sp_clr     (sp_clr),
  .lp_clr     (lp_clr),
  .sys_rst_req(sys_rst_req),
  .sp_flag    (sp_flag),
  .lp_flag    (lp_flag),
  .wake_req   (wake_req),
  .wake_reason(wake_reason)
);

// File: tb/tb_press_rst_ctrl.sv
`timescale 1ns/1ps
module tb_press_rst_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_lvl = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] sp_sel = 3'd0;
  logic [2:0] lp_sel = 3'd0;
  logic [1:0] ack_sel = 2'd0;
  logic       ms_tick = 1'b1;
  logic       sleep_i = 1'b0;
  logic       sp_clr = 1'b0;
  logic       lp_clr = 1'b0;
  logic       sys_rst_req, sp_flag, lp_flag, irq, wake_req;
  logic [1:0] wake_reason;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R11";
  int tick_div = 1;
  int tick_ph = 0;

  always #5 clk = ~clk;

  press_rst_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .mode_sel(mode_sel),
    .sp_sel(sp_sel), .lp_sel(lp_sel), .ack_sel(ack_sel), .ms_tick(ms_tick),
    .sleep_i(sleep_i), .sp_clr(sp_clr), .lp_clr(lp_clr),
    .sys_rst_req(sys_rst_req), .sp_flag(sp_flag), .lp_flag(lp_flag), .irq(irq),
    .wake_req(wake_req), .wake_reason(wake_reason)
  );

  // tick generator: one tick every tick_div cycles
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    ms_tick <= (tick_ph == 0);
  end

  // behavioural reference model
  int   m_ms;
  int   m_stage; // 0 waiting short, 1 short seen, 2 long pending, 3 acknowledged, 4 reset held
  logic m_prev, m_rst, m_sp, m_lp, m_wake;
  logic [1:0] m_why;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ms = 0; m_stage = 0; m_prev = 1; m_rst = 0;
      m_sp = 0; m_lp = 0; m_wake = 0; m_why = 0;
    end else begin
      int t_sp, t_lp, t_rst;
      bit pressed, e_sp, e_lp, e_due;
      t_sp  = 50 * sp_sel;
      t_lp  = t_sp + 1000 + 500 * lp_sel;
      t_rst = t_lp + (50 << ack_sel);
      pressed = (mode_sel == 2'b01) && !pin_lvl;
      e_sp = pressed && m_stage == 0 && m_ms >= t_sp;
      e_lp = pressed && m_stage == 1 && m_ms >= t_lp;
      e_due = pressed && m_stage == 2 && !lp_clr && m_ms >= t_rst;
      m_rst = (mode_sel == 2'b00 && !pin_lvl) || (mode_sel[1] && m_prev && !pin_lvl)
              || (pressed && (m_stage == 4 || e_due));
      m_wake = sleep_i && (e_sp || e_lp);
      m_why  = !sleep_i ? 2'b00 : e_lp ? 2'b10 : e_sp ? 2'b01 : 2'b00;
      m_sp = e_sp || (m_sp && !sp_clr);
      m_lp = e_lp || (m_lp && !lp_clr);
      if (!pressed) m_stage = 0;
      else if (e_sp) m_stage = 1;
      else if (e_lp) m_stage = 2;
      else if (m_stage == 2 && lp_clr) m_stage = 3;
      else if (e_due) m_stage = 4;
      m_prev = pin_lvl;
      if (pin_lvl) m_ms = 0;
      else if (ms_tick && m_ms < 8191) m_ms = m_ms + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, {sys_rst_req, sp_flag, lp_flag, irq, wake_req, wake_reason},
          {m_rst, m_sp, m_lp, m_sp | m_lp, m_wake, m_why});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    sp_clr = 1; lp_clr = 1; cyc(1); sp_clr = 0; lp_clr = 0; cyc(1);
  endtask

  // hold the pin low for 'hold' cycles; record first cycle of each output
  task automatic press(int hold, output int f_sp, output int f_lp, output int f_rst,
                       output int n_rst, output int n_wake);
    f_sp = -1; f_lp = -1; f_rst = -1; n_rst = 0; n_wake = 0;
    pin_lvl = 0;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (sp_flag && f_sp < 0) f_sp = i;
      if (lp_flag && f_lp < 0) f_lp = i;
      if (sys_rst_req && f_rst < 0) f_rst = i;
      if (sys_rst_req) n_rst++;
      if (wake_req) n_wake++;
    end
    pin_lvl = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int a, b, c, d, e;
    cyc(3); rst_n = 1; cyc(2);
    chk("R11", {sp_flag, lp_flag, irq}, 0);
    chk("R1", sys_rst_req, 0);

    // level mode
    cur_req = "R1";
    pin_lvl = 0; cyc(1); chk("R1", sys_rst_req, 1);
    cyc(9); chk("R1", sys_rst_req, 1);
    pin_lvl = 1; cyc(1); chk("R1", sys_rst_req, 0);

    // pulse mode, both codes
    cur_req = "R2";
    mode_sel = 2'b10; cyc(2);
    press(20, a, b, c, d, e); chk("R2", d, 1); chk("R2", c, 1); cyc(3);
    mode_sel = 2'b11; cyc(2);
    press(20, a, b, c, d, e); chk("R2", d, 1); cyc(3);

    // interrupt mode: too-short press
    mode_sel = 2'b01; sp_sel = 3'd1; lp_sel = 3'd0; ack_sel = 2'd0; cyc(2);
    cur_req = "R3";
    press(30, a, b, c, d, e); chk("R3", a, -1); chk("R3", d, 0); cyc(3);

    // short press only
    cur_req = "R4";
    press(200, a, b, c, d, e); chk("R4", a, 51); chk("R4", b, -1); cyc(2);
    cur_req = "R11";
    chk("R11", sp_flag, 1); sp_clr = 1; cyc(1); sp_clr = 0; cyc(1);
    chk("R11", sp_flag, 0);

    // sparse ticks and restarts
    cur_req = "R12";
    tick_div = 4;
    press(120, a, b, c, d, e); chk("R12", a, -1); cyc(2);
    tick_div = 1; cyc(4);
    press(40, a, b, c, d, e); cyc(1);
    press(40, a, b, c, d, e); chk("R12", a, -1); cyc(2);

    // long press acknowledged, then held much longer
    cur_req = "R5";
    pin_lvl = 0; a = 0;
    for (int i = 1; i <= 1100 && !lp_flag; i++) begin @(negedge clk); a = i; end
    chk("R5", a, 1051); chk("R5", sp_flag, 1);
    cyc(5); cur_req = "R7";
    lp_clr = 1; sp_clr = 1; cyc(1); lp_clr = 0; sp_clr = 0;
    d = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (sys_rst_req || sp_flag || lp_flag) d++;
    end
    chk("R7", d, 0);
    pin_lvl = 1; cyc(3);

    // unacknowledged long press, Tack 200
    cur_req = "R6";
    sp_sel = 3'd0; ack_sel = 2'd2; cyc(2);
    press(1300, a, b, c, d, e);
    chk("R6", a, 1); chk("R6", b, 1001); chk("R6", c, 1201); chk("R6", d, 100);
    cyc(1); chk("R6", sys_rst_req, 0);
    clear_flags();

    // release one tick before the reset deadline
    cur_req = "R8";
    ack_sel = 2'd0; cyc(2);
    press(1050, a, b, c, d, e); chk("R8", d, 0); chk("R8", b, 1001); cyc(2);
    clear_flags();

    // wake requests while asleep
    cur_req = "R9";
    sleep_i = 1; cyc(1);
    pin_lvl = 0; d = 0; e = 0;
    for (int i = 0; i < 1020; i++) begin
      @(negedge clk);
      if (wake_req) begin
        e++;
        d = d * 4 + int'(wake_reason);
      end
    end
    pin_lvl = 1;
    chk("R9", e, 2); chk("R9", d, 6);
    cyc(2); sleep_i = 0; clear_flags();
    press(1020, a, b, c, d, e); chk("R9", e, 0); cyc(2);
    clear_flags();

    // select mapping, largest codes and a middle set
    cur_req = "R10";
    sp_sel = 3'd7; lp_sel = 3'd7; ack_sel = 2'd3; cyc(2);
    press(5300, a, b, c, d, e);
    chk("R10", a, 351); chk("R10", b, 4851); chk("R10", c, 5251); cyc(2);
    clear_flags();
    sp_sel = 3'd3; lp_sel = 3'd2; ack_sel = 2'd1; cyc(2);
    press(2300, a, b, c, d, e);
    chk("R10", a, 151); chk("R10", b, 2151); chk("R10", c, 2251); cyc(2);
    clear_flags();

    // set wins over a clear strobe held through the event
    cur_req = "R11";
    sp_sel = 3'd1; cyc(2);
    sp_clr = 1; pin_lvl = 0; d = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sp_flag) d++;
    end
    pin_lvl = 1; sp_clr = 0;
    chk("R11", d, 1);
    cyc(5);

    summary();
  end

endmodule